// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an on-chip circular RAM so that a debug host can later read back what happened around an event of interest. Capture runs while the enable bit of the control register is set; each accepted word lands at the write pointer, which wraps back to zero at the end of the RAM. A trigger strobe starts a post-trigger countdown. Once the programmed number of words has been stored after the trigger, acquisition completes and the RAM is frozen.

The host reaches nine 32-bit registers through a simple read/write port. Read data appears on the cycle after the read strobe and is held until the next read. A typical session goes like this: load the trigger counter, zero the write pointer, then set the enable bit. Next, poll status until acquisition is complete and the input pipeline is empty. If the wrap flag is set, the host points the read pointer at the write pointer; otherwise it points it at zero. Finally, it streams the words out through the data register, which advances the read pointer on every read. In the alternate input mode, each trace beat carries a 16-bit half word. Two beats are packed into one stored word.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, the status register reads 0x8 (only bit 3, pipeline empty, set). The read pointer, write pointer, trigger counter and control register read 0, and the read data output is 0.
- R2: The register addresses are: 0 identification (the ID_VALUE parameter), 1 RAM depth in words, 2 RAM width (32), 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 trigger counter, 8 control. Control bit 0 enables capture, control bit 1 selects half-word input mode, and both read back.
- R3: With control bit 0 set and bit 1 clear, every cycle with the valid strobe high stores that word at the write pointer. The write pointer advances by one, modulo the depth. No word is stored while bit 0 is clear.
- R4: With control bits 1 and 0 both set, the low 16 bits of two successive valid beats form one stored word, with the first beat in bits 15:0 and the second in bits 31:16.
- R5: Status bit 0 (wrapped) is set when a word is stored at the last address. The write pointer then continues at 0.
- R6: A trigger strobe while capturing sets status bit 1. Each stored word counts down the trigger counter, starting with the word accepted in the trigger cycle. When the counter is zero after a trigger, status bit 2 (complete) sets and no further word is stored.
- R7: A trigger arriving while the trigger counter holds 0 completes acquisition with no word stored after the trigger.
- R8: Status bit 3 is low while a word or an unpaired half word is still in the input pipeline. It is high from one cycle after acquisition completes.
- R9: A read of address 4 returns the word at the read pointer on the next cycle and advances the read pointer by one, modulo the depth.
- R10: The read pointer, write pointer and trigger counter are writable and read back their current values. Writes to addresses 0 to 4 and above 8 change nothing, and reads above 8 return 0.
- R11: Clearing control bit 0 stops capture and keeps status bits 0 to 2. Setting bit 0 while it is clear resets status bits 0 to 2.
- R12: A trigger or a valid word arriving while capture is disabled changes no status bit and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trc_data | input | 32 | Incoming trace word |
| trc_valid | input | 1 | Trace word strobe |
| trc_trigger | input | 1 | Trigger event strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| stat_full | output | 1 | Write pointer has wrapped |
| stat_triggered | output | 1 | Trigger seen during this capture |
| stat_acq_done | output | 1 | Post-trigger countdown finished |
| stat_pipe_empty | output | 1 | Input pipeline holds no pending data |

## Verification
The bench goes after an off-by-one in the post-trigger count. Counting from the word after the trigger would store one extra word and leave the write pointer one further on. It also runs enough words to wrap the RAM, so a pointer that fails to wrap, or a wrap flag that does not stick, shows up as a wrong oldest-first readout starting at the write pointer. A zero trigger count, which a wrong design would treat as a wrap to the maximum count, and a stop followed by a restart, which must first keep and then clear the status flags, are both tried. In half-word mode the bench reads status with an unpaired beat pending, and checks the packing order of the stored words.

// File: rtl/tcb_pkg.sv
// Shared constants for the trace capture buffer: register addresses,
// status bit positions and the stored word width.
package tcb_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] RA_ID    = 4'd0;
    localparam logic [ADDR_W-1:0] RA_DEPTH = 4'd1;
    localparam logic [ADDR_W-1:0] RA_WIDTH = 4'd2;
    localparam logic [ADDR_W-1:0] RA_STAT  = 4'd3;
    localparam logic [ADDR_W-1:0] RA_DATA  = 4'd4;
    localparam logic [ADDR_W-1:0] RA_RPTR  = 4'd5;
    localparam logic [ADDR_W-1:0] RA_WPTR  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_TCNT  = 4'd7;
    localparam logic [ADDR_W-1:0] RA_CTRL  = 4'd8;

    localparam int unsigned SB_FULL  = 0;
    localparam int unsigned SB_TRIG  = 1;
    localparam int unsigned SB_DONE  = 2;
    localparam int unsigned SB_EMPTY = 3;

    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_HALF  = 1;
endpackage

// File: rtl/tcb_front.sv
// Input formatter. Registers accepted trace words for one cycle before
// they are stored. In half-word mode it pairs two beats into one word.
// Assumes: capture_on already includes the enable and not-complete terms.
// While capture is off, it drops any staged or unpaired data.
module tcb_front
    import tcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_on,
    input  logic              half_mode,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic [WORD_W-1:0] stg_data,
    output logic              stg_vld,
    output logic              pipe_empty
);
    logic [HALF_W-1:0] half_q;
    logic              half_pend;

    // Stage register and half-word pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_data  <= '0;
            stg_vld   <= 1'b0;
            half_q    <= '0;
            half_pend <= 1'b0;
        end else if (!capture_on) begin
            stg_vld   <= 1'b0;
            half_pend <= 1'b0;
        end else begin
            stg_vld <= 1'b0;
            if (in_valid) begin
                if (!half_mode) begin
                    stg_data <= in_data;
                    stg_vld  <= 1'b1;
                end else if (half_pend) begin
                    stg_data  <= {in_data[HALF_W-1:0], half_q};
                    stg_vld   <= 1'b1;
                    half_pend <= 1'b0;
                end else begin
                    half_q    <= in_data[HALF_W-1:0];
                    half_pend <= 1'b1;
                end
            end
        end
    end

    // Pipeline holds nothing that still has to reach the RAM.
    always_comb pipe_empty = !stg_vld && !half_pend;
endmodule

// File: rtl/tcb_capture.sv
// Capture sequencer. Owns the write pointer, the post-trigger counter and
// the wrapped/triggered/complete flags, and decides when a staged word is
// written. Assumes DEPTH is a power of two, so a host pointer load fits.
// A host load of a pointer or the counter takes priority over capture.
module tcb_capture #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4,
    parameter int unsigned CW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          start,
    input  logic          trig_in,
    input  logic          stg_vld,
    input  logic          wptr_ld,
    input  logic [AW-1:0] wptr_val,
    input  logic          tcnt_ld,
    input  logic [CW-1:0] tcnt_val,
    output logic          mem_we,
    output logic [AW-1:0] wptr,
    output logic [CW-1:0] tcnt,
    output logic          full,
    output logic          trig_seen,
    output logic          acq_done
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic stop_now;

    // Countdown has expired after a trigger: no more words may land.
    always_comb stop_now = trig_seen && (tcnt == '0);

    // Store the staged word only while capture is live.
    always_comb mem_we = stg_vld && cap_en && !acq_done && !stop_now;

    // Write pointer: host load, else advance with wrap on each store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (wptr_ld)
            wptr <= wptr_val;
        else if (mem_we)
            wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
    end

    // Post-trigger counter: host load, else count down stored words after trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (tcnt_ld)
            tcnt <= tcnt_val;
        else if (mem_we && trig_seen)
            tcnt <= tcnt - CW'(1);
    end

    // Sticky status flags, cleared only when a new capture starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            trig_seen <= 1'b0;
            acq_done  <= 1'b0;
        end else if (start) begin
            full      <= 1'b0;
            trig_seen <= 1'b0;
            acq_done  <= 1'b0;
        end else begin
            if (mem_we && wptr == LAST)
                full <= 1'b1;
            if (cap_en && !acq_done && trig_in)
                trig_seen <= 1'b1;
            if (cap_en && stop_now)
                acq_done <= 1'b1;
        end
    end
endmodule

// File: rtl/tcb_mem.sv
// Trace storage: one write port for capture, one registered read port for
// the host. The array has no reset, while the read output register does.
module tcb_mem
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Capture write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Host read, registered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/tcb_host.sv
// Host register file. Holds control and the read pointer, decodes writes
// into load strobes for the capture sequencer, and returns registered read
// data one cycle after a read strobe, held until the next read.
module tcb_host
    import tcb_pkg::*;
#(
    parameter int unsigned       DEPTH    = 16,
    parameter int unsigned       AW       = 4,
    parameter int unsigned       CW       = 32,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h7C5B_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [3:0]        status,
    input  logic [AW-1:0]     wptr,
    input  logic [CW-1:0]     tcnt,
    input  logic [WORD_W-1:0] ram_q,
    output logic              ctrl_en,
    output logic              ctrl_half,
    output logic              start,
    output logic              wptr_ld,
    output logic              tcnt_ld,
    output logic [AW-1:0]     ld_ptr,
    output logic [CW-1:0]     ld_cnt,
    output logic [AW-1:0]     rptr,
    output logic              ram_re,
    output logic [WORD_W-1:0] host_rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WORD_W-1:0] rd_val;
    logic [WORD_W-1:0] val_q;
    logic              sel_ram_q;

    // Write decode toward the capture sequencer.
    always_comb begin
        wptr_ld = host_wr && (host_addr == RA_WPTR);
        tcnt_ld = host_wr && (host_addr == RA_TCNT);
        ld_ptr  = host_wdata[AW-1:0];
        ld_cnt  = host_wdata[CW-1:0];
        start   = host_wr && (host_addr == RA_CTRL) && host_wdata[CB_EN] && !ctrl_en;
        ram_re  = host_rd && (host_addr == RA_DATA);
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_half <= 1'b0;
        end else if (host_wr && host_addr == RA_CTRL) begin
            ctrl_en   <= host_wdata[CB_EN];
            ctrl_half <= host_wdata[CB_HALF];
        end
    end

    // Read pointer: host load, else step past each data read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (host_wr && host_addr == RA_RPTR)
            rptr <= host_wdata[AW-1:0];
        else if (ram_re)
            rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
    end

    // Value of the addressed non-RAM register.
    always_comb begin
        case (host_addr)
            RA_ID:    rd_val = ID_VALUE;
            RA_DEPTH: rd_val = WORD_W'(DEPTH);
            RA_WIDTH: rd_val = WORD_W'(WORD_W);
            RA_STAT:  rd_val = {{(WORD_W-4){1'b0}}, status};
            RA_RPTR:  rd_val = {{(WORD_W-AW){1'b0}}, rptr};
            RA_WPTR:  rd_val = {{(WORD_W-AW){1'b0}}, wptr};
            RA_TCNT:  rd_val = WORD_W'(tcnt);
            RA_CTRL:  rd_val = {{(WORD_W-2){1'b0}}, ctrl_half, ctrl_en};
            default:  rd_val = '0;
        endcase
    end

    // Snapshot of the read result, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q     <= '0;
            sel_ram_q <= 1'b0;
        end else if (host_rd) begin
            val_q     <= rd_val;
            sel_ram_q <= (host_addr == RA_DATA);
        end
    end

    // Read data comes from the RAM port or the snapshot.
    always_comb host_rdata = sel_ram_q ? ram_q : val_q;
endmodule

// File: rtl/trace_capture_buf.sv
// Circular trace capture buffer top. Wires the input formatter, the capture
// sequencer, the storage array and the host register file together.
// Assumes DEPTH is a power of two and at least 2, and that CW is at most 32.
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int unsigned       DEPTH    = 16,
    parameter int unsigned       CW       = 32,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h7C5B_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] trc_data,
    input  logic              trc_valid,
    input  logic              trc_trigger,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [WORD_W-1:0] host_rdata,
    output logic              stat_full,
    output logic              stat_triggered,
    output logic              stat_acq_done,
    output logic              stat_pipe_empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              ctrl_en, ctrl_half, start;
    logic              wptr_ld, tcnt_ld, ram_re, mem_we;
    logic [AW-1:0]     ld_ptr, wptr, rptr;
    logic [CW-1:0]     ld_cnt, tcnt;
    logic [WORD_W-1:0] stg_data, ram_q;
    logic              stg_vld, capture_on;
    logic [3:0]        status;

    // Formatter runs only while capture is live.
    always_comb capture_on = ctrl_en && !stat_acq_done;

    // Status word in register bit order.
    always_comb begin
        status           = '0;
        status[SB_FULL]  = stat_full;
        status[SB_TRIG]  = stat_triggered;
        status[SB_DONE]  = stat_acq_done;
        status[SB_EMPTY] = stat_pipe_empty;
    end

    tcb_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_on (capture_on),
        .half_mode  (ctrl_half),
        .in_data    (trc_data),
        .in_valid   (trc_valid),
        .stg_data   (stg_data),
        .stg_vld    (stg_vld),
        .pipe_empty (stat_pipe_empty)
    );

    tcb_capture #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (ctrl_en),
        .start     (start),
        .trig_in   (trc_trigger),
        .stg_vld   (stg_vld),
        .wptr_ld   (wptr_ld),
        .wptr_val  (ld_ptr),
        .tcnt_ld   (tcnt_ld),
        .tcnt_val  (ld_cnt),
        .mem_we    (mem_we),
        .wptr      (wptr),
        .tcnt      (tcnt),
        .full      (stat_full),
        .trig_seen (stat_triggered),
        .acq_done  (stat_acq_done)
    );

    tcb_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (wptr),
        .wdata (stg_data),
        .re    (ram_re),
        .raddr (rptr),
        .rdata (ram_q)
    );

    tcb_host #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .ID_VALUE(ID_VALUE)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .status     (status),
        .wptr       (wptr),
        .tcnt       (tcnt),
        .ram_q      (ram_q),
        .ctrl_en    (ctrl_en),
        .ctrl_half  (ctrl_half),
        .start      (start),
        .wptr_ld    (wptr_ld),
        .tcnt_ld    (tcnt_ld),
        .ld_ptr     (ld_ptr),
        .ld_cnt     (ld_cnt),
        .rptr       (rptr),
        .ram_re     (ram_re),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/tcb_chk.sv
// Property checker for the trace capture buffer, attached by bind.
// It watches status outputs, host strobes and internal pointer/strobe nets.
module tcb_chk
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic              ctrl_en,
    input logic              start,
    input logic              mem_we,
    input logic [AW-1:0]     rptr,
    input logic              stat_full,
    input logic              stat_triggered,
    input logic              stat_acq_done,
    input logic              stat_pipe_empty
);
    // R6
    done_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_acq_done |-> stat_triggered);

    // R6
    no_store_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_acq_done |-> !mem_we);

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !start) |=> ($stable(stat_full) && $stable(stat_triggered)
                                  && $stable(stat_acq_done)));

    // R5
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_full) |-> $past(start));

    // R9
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == RA_DATA) |=>
            (rptr == (($past(rptr) == AW'(DEPTH - 1)) ? '0 : $past(rptr) + AW'(1))));

    // R8
    drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_acq_done && $past(stat_acq_done)) |-> stat_pipe_empty);
endmodule

bind trace_capture_buf tcb_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_rd         (host_rd),
    .host_addr       (host_addr),
    .ctrl_en         (ctrl_en),
    .start           (start),
    .mem_we          (mem_we),
    .rptr            (rptr),
    .stat_full       (stat_full),
    .stat_triggered  (stat_triggered),
    .stat_acq_done   (stat_acq_done),
    .stat_pipe_empty (stat_pipe_empty)
);

// File: tb/trace_capture_buf_tb.sv
`timescale 1ns/1ps
module trace_capture_buf_tb;
    localparam logic [31:0] ID  = 32'h7C5B_0001;
    localparam int          DEP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] trc_data = '0;
    logic        trc_valid = 1'b0;
    logic        trc_trigger = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_rdata;
    logic        stat_full, stat_triggered, stat_acq_done, stat_pipe_empty;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEP), .CW(32), .ID_VALUE(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .trc_data(trc_data), .trc_valid(trc_valid),
        .trc_trigger(trc_trigger), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .stat_full(stat_full), .stat_triggered(stat_triggered),
        .stat_acq_done(stat_acq_done), .stat_pipe_empty(stat_pipe_empty)
    );

    // Vector: {op[1:0] 1=write 2=read, addr[3:0], data/expect[31:0], req[3:0]}
    localparam int NV = 24;
    localparam logic [41:0] VEC [NV] = '{
        {2'd2, 4'd0,  ID,            4'd2},   // R2 id
        {2'd2, 4'd1,  32'd16,        4'd2},   // R2 depth
        {2'd2, 4'd2,  32'd32,        4'd2},   // R2 width
        {2'd2, 4'd3,  32'h8,         4'd1},   // R1 status
        {2'd2, 4'd5,  32'h0,         4'd1},   // R1 rptr
        {2'd2, 4'd6,  32'h0,         4'd1},   // R1 wptr
        {2'd2, 4'd7,  32'h0,         4'd1},   // R1 tcnt
        {2'd2, 4'd8,  32'h0,         4'd1},   // R1 ctrl
        {2'd1, 4'd7,  32'h1234,      4'd10},  // R10 tcnt write
        {2'd2, 4'd7,  32'h1234,      4'd10},
        {2'd1, 4'd0,  32'hFFFF_FFFF, 4'd10},  // R10 id is read-only
        {2'd2, 4'd0,  ID,            4'd10},
        {2'd1, 4'd5,  32'h3,         4'd10},  // R10 rptr write
        {2'd2, 4'd5,  32'h3,         4'd10},
        {2'd1, 4'd5,  32'h0,         4'd10},
        {2'd1, 4'd6,  32'h9,         4'd10},  // R10 wptr write
        {2'd2, 4'd6,  32'h9,         4'd10},
        {2'd1, 4'd6,  32'h0,         4'd10},
        {2'd1, 4'd13, 32'h5,         4'd10},  // R10 unmapped
        {2'd2, 4'd13, 32'h0,         4'd10},
        {2'd1, 4'd3,  32'hF,         4'd10},  // R10 status read-only
        {2'd2, 4'd3,  32'h8,         4'd10},
        {2'd2, 4'd5,  32'h0,         4'd10},
        {2'd2, 4'd6,  32'h0,         4'd10}
    };

    function automatic logic [31:0] wv(input int i);
        return 32'hA500_0000 | (32'(i) * 32'h0001_0101);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic push(input logic [31:0] d, input logic t);
        @(negedge clk);
        trc_data = d; trc_valid = 1'b1; trc_trigger = t;
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic trig_only();
        @(negedge clk);
        trc_trigger = 1'b1;
        @(negedge clk);
        trc_trigger = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 read data output after reset
        chk("R1", "rdata after reset", host_rdata, 32'h0);
        chk("R1", "status pins after reset",
            {28'h0, stat_pipe_empty, stat_acq_done, stat_triggered, stat_full}, 32'h8);

        // Register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41:40] == 2'd1)
                hwr(VEC[i][39:36], VEC[i][35:4]);
            else begin
                hrd(VEC[i][39:36], r);
                chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("vector %0d", i), r, VEC[i][35:4]);
            end
        end

        // Normal capture with post-trigger count 3
        hwr(4'd7, 32'd3);
        hwr(4'd6, 32'd0);
        hwr(4'd8, 32'd1);
        for (int i = 0; i < 5; i++) push(wv(i), 1'b0);
        idle(3);
        hrd(4'd6, r);  chk("R3", "wptr after 5 words", r, 32'd5);
        hrd(4'd3, r);  chk("R3", "status before trigger", r, 32'h8);
        push(wv(5), 1'b1);
        push(wv(6), 1'b0);
        idle(2);
        hrd(4'd3, r);  chk("R6", "status mid countdown", r, 32'hA);
        hrd(4'd7, r);  chk("R6", "count after 2 post words", r, 32'd1);
        push(wv(7), 1'b0);
        idle(3);
        push(wv(8), 1'b0);
        idle(3);
        hrd(4'd3, r);  chk("R6", "status complete", r, 32'hE);
        hrd(4'd6, r);  chk("R6", "wptr frozen at 8", r, 32'd8);
        hwr(4'd5, 32'd0);
        for (int i = 0; i < 8; i++) begin
            hrd(4'd4, r);
            chk("R9", $sformatf("readout %0d", i), r, wv(i));
        end
        hrd(4'd5, r);  chk("R9", "rptr after 8 reads", r, 32'd8);

        // Stop keeps status; disabled inputs ignored
        hwr(4'd8, 32'd0);
        hrd(4'd3, r);  chk("R11", "status kept after stop", r, 32'hE);
        push(wv(50), 1'b1);
        idle(3);
        hrd(4'd6, r);  chk("R12", "wptr while disabled", r, 32'd8);
        hrd(4'd3, r);  chk("R12", "status while disabled", r, 32'hE);

        // Restart, wrap and oldest-first readout
        hwr(4'd7, 32'd2);
        hwr(4'd6, 32'd0);
        hwr(4'd8, 32'd1);
        hrd(4'd3, r);  chk("R11", "status cleared on start", r, 32'h8);
        for (int i = 0; i < 20; i++) push(wv(32 + i), 1'b0);
        idle(3);
        hrd(4'd6, r);  chk("R5", "wptr wrapped", r, 32'd4);
        hrd(4'd3, r);  chk("R5", "wrapped flag", r, 32'h9);
        push(wv(52), 1'b1);
        push(wv(53), 1'b0);
        push(wv(54), 1'b0);
        idle(3);
        hrd(4'd3, r);  chk("R6", "status after wrap and done", r, 32'hF);
        hrd(4'd6, r);  chk("R6", "wptr after wrap capture", r, 32'd6);
        hwr(4'd5, 32'd6);
        for (int k = 0; k < DEP; k++) begin
            hrd(4'd4, r);
            chk("R5", $sformatf("oldest-first %0d", k), r, wv(32 + 6 + k));
        end
        hrd(4'd5, r);  chk("R9", "rptr wraps back", r, 32'd6);

        // Half-word mode, then zero post-trigger count
        hwr(4'd8, 32'd0);
        hwr(4'd7, 32'd0);
        hwr(4'd6, 32'd0);
        hwr(4'd8, 32'd3);
        hrd(4'd8, r);  chk("R2", "control readback", r, 32'h3);
        push(32'hAAAA_1111, 1'b0);
        push(32'hBBBB_2222, 1'b0);
        push(32'hCCCC_3333, 1'b0);
        idle(2);
        hrd(4'd3, r);  chk("R8", "half word pending", r, 32'h0);
        hrd(4'd6, r);  chk("R4", "one packed word", r, 32'd1);
        push(32'hDDDD_4444, 1'b0);
        idle(3);
        hrd(4'd3, r);  chk("R8", "pipeline drained", r, 32'h8);
        trig_only();
        idle(3);
        hrd(4'd3, r);  chk("R7", "done with zero count", r, 32'hE);
        push(32'h1234_5678, 1'b0);
        push(32'h9ABC_DEF0, 1'b0);
        idle(3);
        hrd(4'd6, r);  chk("R7", "no post-trigger store", r, 32'd2);
        hwr(4'd5, 32'd0);
        hrd(4'd4, r);  chk("R4", "packed word 0", r, 32'h2222_1111);
        hrd(4'd4, r);  chk("R4", "packed word 1", r, 32'h4444_3333);

        done_flag = 1'b1;
        finish_run();
    end
endmodule